// File: doc/BRIEF.md
# ATA Taskfile Command Sequencer

The block receives an already-decoded command descriptor and turns it into a burst of single-cycle accesses to the eight ATA taskfile registers. It works over a simple register bus. The descriptor carries the following fields:

- a mode flag that chooses between "write the registers and execute" and "read the registers back only";
- a flag that places the Device/Head write either before or after the command-register write;
- an 8-bit mask that picks which registers are touched;
- eight write bytes;
- a sectors-per-block byte;
- the host transfer length;
- three bytes that must be zero.

Before any bus activity, the sequencer checks the descriptor. An illegal sectors-per-block value, a nonzero reserved byte, or a read-back request whose length is not 8 ends the command at once with a failed status. Otherwise the selected registers are visited in a fixed order, one access per cycle. In read-back mode an 8-byte result buffer is filled, and zeros are left for registers that were not picked. A one-cycle done pulse marks the end. The status and the buffer stay held until the next accepted start.

Top module: `tf_cmd_seq`

## Requirements
- R1: During and after reset, and until the first start, `done`, `fail`, `bus_wr` and `bus_rd` are 0 and `rd_buf` is all zeros.
- R2: Register index i (0..7) is accessed only if `reg_sel[i]` is 1. Accesses go in ascending index order, one per cycle, back to back, starting the cycle after the start cycle. Each register is accessed at most once.
- R3: When `rd_only` is 0, every access is a write (`bus_wr`=1). `bus_wdata` for index i equals `wr_bytes[8*i+7:8*i]`.
- R4: When `rd_only` is 0 and `dev_after` is 1, the index-7 (command) write comes before the index-6 (Device/Head) write. The order of all other writes is unchanged. When `dev_after` is 0, index 6 comes before index 7.
- R5: When `rd_only` is 1, every access is a read, in plain ascending order whatever `dev_after` says. `rd_buf[8*i+7:8*i]` takes the value on `bus_rdata` in the cycle after the read strobe for index i. It holds 0x00 for every unselected index.
- R6: `blk_count` values 0, 1, 2, 4, 8, 16, 32, 64 and 128 are accepted. Any other value sets `fail` and causes no bus access.
- R7: Any nonzero bit in `rsvd` sets `fail` and causes no bus access.
- R8: When `rd_only` is 1 and `xfer_len` is not 8, `fail` is set and no bus access occurs. When `rd_only` is 0, `xfer_len` has no effect.
- R9: `done` is high for exactly one cycle. For an accepted command with N selected registers, it is high N+2 cycles after the start cycle. For a rejected command, it is high in the cycle right after the start cycle.
- R10: `fail` and `rd_buf` keep their values until the next accepted start. A `start` that arrives while a command is running is ignored.
- R11: `bus_wr` and `bus_rd` are never high in the same cycle. Neither strobe is high while the sequencer is idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Start pulse; taken only when idle |
| rd_only | input | 1 | 1 = read back the selected registers only; 0 = write and execute |
| dev_after | input | 1 | 1 = Device/Head write after the command write |
| reg_sel | input | 8 | Bit i selects taskfile register i |
| wr_bytes | input | 64 | Write byte for register i in bits 8i+7:8i |
| blk_count | input | 8 | Sectors per block (0 means 256) |
| xfer_len | input | 32 | Host transfer length |
| rsvd | input | 24 | Reserved bytes; must be zero |
| bus_idx | output | 3 | Taskfile register index of the current access |
| bus_wdata | output | 8 | Write data |
| bus_wr | output | 1 | Write strobe |
| bus_rd | output | 1 | Read strobe |
| bus_rdata | input | 8 | Read data, valid the cycle after `bus_rd` |
| rd_buf | output | 64 | Read-back result, byte i in bits 8i+7:8i |
| done | output | 1 | One-cycle end-of-command pulse |
| fail | output | 1 | Failed status of the last command |

## Verification
Suppose the remaining-register set is wrong. That shows up on the bus during the very next cycle of the burst, as a skipped, repeated or out-of-order `bus_idx`. It also moves `done` away from its N+2 cycle slot. If the order swap is mislatched, the 6/7 pair swaps in the wrong mode. A read-capture index that is off lands a byte in the wrong lane of `rd_buf`, and this is visible the cycle `done` rises. If the validation state is wrong, bus strobes appear on a rejected command, or `done` arrives one cycle after start on a command that should have run.

// File: rtl/tf_seq_pkg.sv
// Package: shared constants, the sequencer state type and the
// position-to-register mapping used by the taskfile sequencer.
// Assumes eight taskfile registers, with Device/Head and Command at the top.
package tf_seq_pkg;
    localparam int NREG    = 8;
    localparam int DW      = 8;
    localparam int IDXW    = $clog2(NREG);
    localparam int DEV_IDX = NREG - 2;
    localparam int CMD_IDX = NREG - 1;

    typedef enum logic [0:0] {S_IDLE = 1'b0, S_RUN = 1'b1} seq_state_t;

    // Maps a sequence slot to a register index; swap moves Device/Head after Command.
    function automatic logic [IDXW-1:0] slot_to_idx(input logic [IDXW-1:0] slot,
                                                    input logic swap);
        if (swap && slot == IDXW'(DEV_IDX))      return IDXW'(CMD_IDX);
        else if (swap && slot == IDXW'(CMD_IDX)) return IDXW'(DEV_IDX);
        else                                     return slot;
    endfunction
endpackage

// File: rtl/tf_cmd_check.sv
// Module: descriptor validation. Purely combinational. Accepts a command only
// if the block count is zero or a power of two that fits in the field, the
// reserved bytes are zero, and a read-back request carries the fixed length.
module tf_cmd_check #(
    parameter int BCW    = 8,
    parameter int LENW   = 32,
    parameter int RSVW   = 24,
    parameter int RD_LEN = 8
) (
    input  logic            rd_only,
    input  logic [BCW-1:0]  blk_count,
    input  logic [LENW-1:0] xfer_len,
    input  logic [RSVW-1:0] rsvd,
    output logic            cmd_ok
);
    logic blk_ok, rsv_ok, len_ok;

    // Combines the three legality tests into one accept flag.
    always_comb begin
        blk_ok = ($countones(blk_count) <= 1);
        rsv_ok = (rsvd == '0);
        len_ok = !rd_only || (xfer_len == LENW'(RD_LEN));
        cmd_ok = blk_ok && rsv_ok && len_ok;
    end
endmodule

// File: rtl/tf_slot_pick.sv
// Module: lowest-set-bit picker over the remaining-slot vector. Combinational.
// Reports whether any slot remains, which slot is lowest, and its one-hot mask.
module tf_slot_pick #(
    parameter int N = 8,
    localparam int W = $clog2(N)
) (
    input  logic [N-1:0] remain,
    output logic         hit,
    output logic [W-1:0] slot,
    output logic [N-1:0] slot_oh
);
    // Scans from the top down so that the lowest set slot wins.
    always_comb begin
        hit     = 1'b0;
        slot    = '0;
        slot_oh = '0;
        for (int k = N - 1; k >= 0; k--) begin
            if (remain[k]) begin
                hit     = 1'b1;
                slot    = W'(k);
                slot_oh = N'(1) << k;
            end
        end
    end
endmodule

// File: rtl/tf_read_buf.sv
// Module: read-back result buffer. It clears on an accepted start and
// captures one byte lane when asked. Assumes cap_idx < N.
module tf_read_buf #(
    parameter int N  = 8,
    parameter int DW = 8,
    localparam int W = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          cap_en,
    input  logic [W-1:0]  cap_idx,
    input  logic [DW-1:0] cap_data,
    output logic [N*DW-1:0] buf_q
);
    // Each lane clears on start or reset and loads when its index is captured.
    for (genvar g = 0; g < N; g++) begin : g_lane
        always_ff @(posedge clk) begin
            if (!rst_n || clear)                  buf_q[g*DW +: DW] <= '0;
            else if (cap_en && cap_idx == W'(g))  buf_q[g*DW +: DW] <= cap_data;
        end
    end
endmodule

// File: rtl/tf_cmd_seq.sv
// Module: ATA taskfile command sequencer (top). On an accepted start it latches
// the descriptor, validates it, then issues one register access per cycle over
// the selected registers in slot order. Read data is captured one cycle after
// each read strobe. Assumes the register bus answers a read in the next cycle.
module tf_cmd_seq
    import tf_seq_pkg::*;
#(
    parameter int LENW   = 32,
    parameter int RSVW   = 24,
    parameter int RD_LEN = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             rd_only,
    input  logic             dev_after,
    input  logic [NREG-1:0]  reg_sel,
    input  logic [NREG*DW-1:0] wr_bytes,
    input  logic [7:0]       blk_count,
    input  logic [LENW-1:0]  xfer_len,
    input  logic [RSVW-1:0]  rsvd,
    output logic [IDXW-1:0]  bus_idx,
    output logic [DW-1:0]    bus_wdata,
    output logic             bus_wr,
    output logic             bus_rd,
    input  logic [DW-1:0]    bus_rdata,
    output logic [NREG*DW-1:0] rd_buf,
    output logic             done,
    output logic             fail
);
    seq_state_t          state_q;
    logic [NREG-1:0]     remain_q;
    logic                rd_q, swap_q;
    logic [NREG*DW-1:0]  wdat_q;
    logic                pend_q;
    logic [IDXW-1:0]     pend_idx_q;
    logic                done_q, fail_q;

    logic                cmd_ok, accept, swap_in;
    logic [NREG-1:0]     slot_mask;
    logic                pick_hit;
    logic [IDXW-1:0]     pick_slot, cur_idx;
    logic [NREG-1:0]     pick_oh;

    assign accept  = start && (state_q == S_IDLE);
    assign swap_in = !rd_only && dev_after;

    tf_cmd_check #(.BCW(8), .LENW(LENW), .RSVW(RSVW), .RD_LEN(RD_LEN)) u_check (
        .rd_only   (rd_only),
        .blk_count (blk_count),
        .xfer_len  (xfer_len),
        .rsvd      (rsvd),
        .cmd_ok    (cmd_ok)
    );

    // Reorders the select mask into slot order for the requested sequence.
    for (genvar p = 0; p < NREG; p++) begin : g_slot
        assign slot_mask[p] = reg_sel[slot_to_idx(IDXW'(p), swap_in)];
    end

    tf_slot_pick #(.N(NREG)) u_pick (
        .remain  (remain_q),
        .hit     (pick_hit),
        .slot    (pick_slot),
        .slot_oh (pick_oh)
    );

    assign cur_idx = slot_to_idx(pick_slot, swap_q);

    // Drives the register bus from the current lowest remaining slot.
    always_comb begin
        bus_wr    = (state_q == S_RUN) && pick_hit && !rd_q;
        bus_rd    = (state_q == S_RUN) && pick_hit && rd_q;
        bus_idx   = pick_hit ? cur_idx : '0;
        bus_wdata = bus_wr ? wdat_q[cur_idx*DW +: DW] : '0;
    end

    // Sequencer control: accept, step through slots, finish with a done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= S_IDLE;
            remain_q   <= '0;
            rd_q       <= 1'b0;
            swap_q     <= 1'b0;
            wdat_q     <= '0;
            pend_q     <= 1'b0;
            pend_idx_q <= '0;
            done_q     <= 1'b0;
            fail_q     <= 1'b0;
        end else begin
            done_q <= 1'b0;
            pend_q <= bus_rd;
            if (bus_rd) pend_idx_q <= cur_idx;
            if (accept) begin
                rd_q   <= rd_only;
                swap_q <= swap_in;
                wdat_q <= wr_bytes;
                fail_q <= !cmd_ok;
                if (cmd_ok) begin
                    state_q  <= S_RUN;
                    remain_q <= slot_mask;
                end else begin
                    done_q   <= 1'b1;
                end
            end else if (state_q == S_RUN) begin
                if (pick_hit) begin
                    remain_q <= remain_q & ~pick_oh;
                end else begin
                    state_q <= S_IDLE;
                    done_q  <= 1'b1;
                end
            end
        end
    end

    tf_read_buf #(.N(NREG), .DW(DW)) u_buf (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (accept),
        .cap_en   (pend_q),
        .cap_idx  (pend_idx_q),
        .cap_data (bus_rdata),
        .buf_q    (rd_buf)
    );

    assign done = done_q;
    assign fail = fail_q;

    // R11: the two strobes never overlap.
    a_r11_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && bus_rd));

    // R2: with no swap, back-to-back accesses strictly ascend.
    a_r2_ascending: assert property (@(posedge clk) disable iff (!rst_n)
        ((bus_wr || bus_rd) && !swap_q) |=> (!(bus_wr || bus_rd) || bus_idx > $past(bus_idx)));

    // R9: done lasts a single cycle.
    a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R5: read-back mode issues no write strobe.
    a_r5_no_write_in_read: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_RUN && rd_q) |-> !bus_wr);

    // R10: a start while running leaves the latched mode untouched.
    a_r10_busy_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_RUN && start) |=> ($stable(rd_q) && $stable(swap_q)));

    // R6/R7/R8: a rejected command had no strobe in the cycle before its done.
    a_r6_fail_no_access: assert property (@(posedge clk) disable iff (!rst_n)
        (done && fail) |-> $past(!bus_wr && !bus_rd));

    // R11: no strobe while idle.
    a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_IDLE) |-> !(bus_wr || bus_rd));
endmodule

// File: tb/tf_cmd_seq_test.sv
module tf_cmd_seq_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0, rd_only = 1'b0, dev_after = 1'b0;
    logic [7:0]  reg_sel = '0;
    logic [63:0] wr_bytes = '0;
    logic [7:0]  blk_count = '0;
    logic [31:0] xfer_len = '0;
    logic [23:0] rsvd = '0;
    logic [2:0]  bus_idx;
    logic [7:0]  bus_wdata;
    logic        bus_wr, bus_rd;
    logic [7:0]  bus_rdata = '0;
    logic [63:0] rd_buf;
    logic        done, fail;

    always #2.5 clk = ~clk;   // 200 MHz

    tf_cmd_seq uut (.*);

    int n_checks = 0, n_fail = 0;
    int tcnt = 0, both_cnt = 0;
    logic [2:0] t_idx [16];
    logic       t_wr  [16];
    logic [7:0] t_dat [16];

    function automatic logic [7:0] rdv(input int i);
        return 8'(8'hC0 + i * 5);
    endfunction

    // Register-bus responder: read data appears the cycle after the strobe.
    always @(posedge clk) if (bus_rd) bus_rdata <= rdv(int'(bus_idx));

    // Records every bus access.
    always @(posedge clk) begin
        if (bus_wr && bus_rd) both_cnt = both_cnt + 1;
        if ((bus_wr || bus_rd) && tcnt < 16) begin
            t_idx[tcnt] = bus_idx;
            t_wr[tcnt]  = bus_wr;
            t_dat[tcnt] = bus_wdata;
            tcnt = tcnt + 1;
        end
    end

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    typedef struct packed {
        logic        rd;
        logic        da;
        logic [7:0]  sel;
        logic [7:0]  blk;
        logic [31:0] len;
        logic [23:0] rsv;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 1'b0, 8'hFF, 8'd1,   32'd0,    24'h0},
        '{1'b0, 1'b1, 8'hFF, 8'd16,  32'd0,    24'h0},
        '{1'b0, 1'b1, 8'h42, 8'd0,   32'd0,    24'h0},
        '{1'b1, 1'b0, 8'hA5, 8'd8,   32'd8,    24'h0},
        '{1'b1, 1'b1, 8'hC0, 8'd128, 32'd8,    24'h0},
        '{1'b0, 1'b0, 8'hFF, 8'd3,   32'd0,    24'h0},
        '{1'b0, 1'b0, 8'hFF, 8'd4,   32'd0,    24'h000100},
        '{1'b1, 1'b0, 8'hFF, 8'd2,   32'd12,   24'h0},
        '{1'b0, 1'b0, 8'h00, 8'd2,   32'd0,    24'h0},
        '{1'b0, 1'b0, 8'h81, 8'd64,  32'd1234, 24'h0},
        '{1'b0, 1'b1, 8'hC0, 8'd255, 32'd0,    24'h0}
    };

    function automatic logic [7:0] wbyte(input int v, input int i);
        return 8'(v * 16 + i + 1);
    endfunction

    // Issues one start pulse and returns the cycle count until done.
    task automatic launch(input vec_t c, input int v, output int lat);
        @(negedge clk);
        rd_only = c.rd; dev_after = c.da; reg_sel = c.sel; blk_count = c.blk;
        xfer_len = c.len; rsvd = c.rsv;
        for (int i = 0; i < 8; i++) wr_bytes[i*8 +: 8] = wbyte(v, i);
        tcnt = 0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 1;
        while (!done && lat < 40) begin
            @(negedge clk);
            lat++;
        end
    endtask

    task automatic run_vec(input int v);
        vec_t c = VEC[v];
        int lat, ne;
        logic ok_exp;
        logic [2:0] ord [8];
        logic [63:0] bexp;
        ok_exp = ((c.blk & (c.blk - 8'd1)) == 8'd0) && (c.rsv == 24'd0) &&
                 (!c.rd || c.len == 32'd8);
        ne = 0;
        for (int p = 0; p < 8; p++) begin
            int i = p;
            if (!c.rd && c.da && p == 6) i = 7;
            if (!c.rd && c.da && p == 7) i = 6;
            if (c.sel[i]) begin ord[ne] = 3'(i); ne++; end
        end
        if (!ok_exp) ne = 0;
        launch(c, v, lat);
        check(fail == !ok_exp, "R6/R7/R8 status", 64'(fail), 64'(!ok_exp));
        check(lat == (ok_exp ? ne + 2 : 1), "R9 done latency", 64'(lat),
              64'(ok_exp ? ne + 2 : 1));
        check(tcnt == ne, "R2 access count", 64'(tcnt), 64'(ne));
        for (int k = 0; k < ne && k < tcnt; k++) begin
            check(t_idx[k] == ord[k], "R2/R4 access order", 64'(t_idx[k]), 64'(ord[k]));
            check(t_wr[k] == !c.rd, "R3/R5 access type", 64'(t_wr[k]), 64'(!c.rd));
            if (!c.rd)
                check(t_dat[k] == wbyte(v, int'(ord[k])), "R3 write data",
                      64'(t_dat[k]), 64'(wbyte(v, int'(ord[k]))));
        end
        bexp = '0;
        if (c.rd && ok_exp)
            for (int i = 0; i < 8; i++) if (c.sel[i]) bexp[i*8 +: 8] = rdv(i);
        check(rd_buf == bexp, "R5 read buffer", rd_buf, bexp);
        @(negedge clk);
        check(!done, "R9 single-cycle done", 64'(done), 64'(0));
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin : main
        int lat;
        logic [63:0] hold;
        repeat (3) @(negedge clk);
        check(!done && !fail && !bus_wr && !bus_rd && rd_buf == '0, "R1 reset state",
              {rd_buf[59:0], done, fail, bus_wr, bus_rd}, 64'(0));
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(!done && !fail && !bus_wr && !bus_rd, "R1 idle after reset",
              {60'(0), done, fail, bus_wr, bus_rd}, 64'(0));

        for (int v = 0; v < NV; v++) run_vec(v);

        // R10: the buffer and status hold after a read-back.
        run_vec(3);
        hold = rd_buf;
        repeat (6) @(negedge clk);
        check(rd_buf == hold && !fail, "R10 result held", rd_buf, hold);

        // R10: a second start while busy is ignored.
        @(negedge clk);
        rd_only = 1'b0; dev_after = 1'b0; reg_sel = 8'hFF; blk_count = 8'd1;
        xfer_len = '0; rsvd = '0; tcnt = 0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (2) @(negedge clk);
        rd_only = 1'b1; reg_sel = 8'h01; xfer_len = 32'd8;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 0;
        while (!done && lat < 40) begin @(negedge clk); lat++; end
        check(tcnt == 8, "R10 busy start ignored (count)", 64'(tcnt), 64'(8));
        check(t_wr[7] == 1'b1, "R10 busy start ignored (mode)", 64'(t_wr[7]), 64'(1));
        check(both_cnt == 0, "R11 strobe overlap", 64'(both_cnt), 64'(0));

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule